// File: doc/BRIEF.md
# Circular Instruction Prefetch Stack

This block keeps a sliding window of program parcels close to the issue stage of a small processor. It asks a banked local memory for aligned groups of parcels, stores each returned parcel in a circular store split into two banks, and shows the issue stage the parcel at the current program address together with a flag that says whether that parcel is present. While the program runs straight ahead, fetching continues in the background. It stops only when the window would overwrite parcels the program may still need.

For each branch taken at the issue point, the block decides whether the target can be served from the window. Short forward hops and short backward hops stay inside the window and cost no memory traffic. Absolute jumps, and relative jumps outside the fixed hop windows, flush the window. The fill then restarts from buffer slot 0 with the aligned group that holds the target. Parcels that were still in flight from the old window are counted and thrown away when they arrive.

Top module: `pfs_prefetch_stack`

## Requirements
- R1: After reset, issue_valid is 0, issue_addr equals RESET_PC (default 0), and req_valid is 1 with req_addr equal to RESET_PC rounded down to a multiple of BURST.
- R2: Every request address is a multiple of BURST (4). Requests run at consecutive group addresses from the current base. A request is raised only when no discarded parcels are pending and (next request address + BURST − issue_addr), taken as a signed AW-bit value, is at most LOOKAHEAD (20).
- R3: Accepted parcels are stored in arrival order. Address a lives in slot (a − base) mod DEPTH, with DEPTH = 32, so after DEPTH parcels the oldest is overwritten. Whenever issue_valid is 1, issue_parcel equals the parcel the memory returned for issue_addr.
- R4: issue_valid is 1 exactly when issue_addr lies in the range of resident addresses, from max(base, fill end − DEPTH) up to but not including the fill end. An issue (issue_valid=1, stall=0) without a branch advances issue_addr by 1.
- R5: While stall is 1, issue_addr holds, and parcels arriving during the stall are still stored.
- R6: br_kind 0 (absolute) and 3 (treated as absolute) always flush. issue_addr becomes br_operand, the base becomes br_operand rounded down to a multiple of BURST, the next fill starts at slot 0, and issue_valid is 0 in the following cycle.
- R7: br_kind 1 (forward, target = issue_addr + br_operand) stays in the window when br_operand ≤ 9 and starts no refetch. A larger offset flushes as in R6, with the computed target.
- R8: br_kind 2 (backward, target = issue_addr − br_operand) stays in the window when br_operand ≤ 11, the target is not below the base, and the target is not below (next request address − DEPTH). Otherwise it flushes as in R6.
- R9: Parcels already requested, or returning in the flush cycle, when a flush occurs are discarded and never appear on issue_parcel.
- R10: br_valid is acted on only in a cycle with issue_valid=1 and stall=0. In any other cycle the branch inputs have no effect on issue_addr or on requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | output | 1 | Group fetch request |
| req_ready | input | 1 | Memory takes the request this cycle |
| req_addr | output | AW | First address of the requested group |
| rsp_valid | input | 1 | One returned parcel this cycle |
| rsp_data | input | DW | Returned parcel, in request order |
| br_valid | input | 1 | Branch outcome for the parcel at issue_addr |
| br_kind | input | 2 | 0 absolute, 1 forward, 2 backward, 3 absolute |
| br_operand | input | AW | Absolute target or relative offset |
| stall | input | 1 | Issue stage cannot take a parcel |
| issue_valid | output | 1 | Parcel at issue_addr is resident |
| issue_addr | output | AW | Current program address |
| issue_parcel | output | DW | Parcel at issue_addr |

## Verification
A wrong base tag or write pointer shows up the first time the wrong slot is read. issue_parcel then disagrees with the data returned for issue_addr in that same cycle. A wrong fill count or residency window shows as issue_valid rising too early or staying low, and the request gate shows a wrong req_valid within a cycle. A wrong in-window decision shows either as an unexpected request for the target group or as a missing flush, both visible on the request port by the next cycle. A miscounted discard shows as a stale parcel on issue_parcel once the new window fills.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      BR_ABS = 2'd0,
      BR_FWD = 2'd1,
      BR_BWD = 2'd2,
      BR_ALT = 2'd3
   } br_kind_e;
endpackage

// File: rtl/pfs_branch_resolve.sv
module pfs_branch_resolve
   import pfs_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DEPTH   = 32,
   parameter int FWD_WIN = 9,
   parameter int BWD_WIN = 11
) (
   input  logic [1:0]    kind,
   input  logic [AW-1:0] operand,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] req_end,
   output logic [AW-1:0] target,
   output logic          in_stack
);
   localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);
   localparam logic [AW-1:0] FWD_A   = AW'(FWD_WIN);
   localparam logic [AW-1:0] BWD_A   = AW'(BWD_WIN);

   logic [AW-1:0] fwd_t;
   logic [AW-1:0] bwd_t;
   logic [AW-1:0] d_base;
   logic [AW-1:0] d_floor;
   logic          bwd_ok;

   always_comb begin
      fwd_t   = pc + operand;
      bwd_t   = pc - operand;
      d_base  = bwd_t - base;
      d_floor = bwd_t - (req_end - DEPTH_A);
      bwd_ok  = (operand <= BWD_A) && !d_base[AW-1] && !d_floor[AW-1];
      case (br_kind_e'(kind))
         BR_FWD: begin
            target   = fwd_t;
            in_stack = (operand <= FWD_A);
         end
         BR_BWD: begin
            target   = bwd_t;
            in_stack = bwd_ok;
         end
         default: begin
            target   = operand;
            in_stack = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/pfs_fetch_ctl.sv
module pfs_fetch_ctl #(
   parameter int AW         = 16,
   parameter int BURST      = 4,
   parameter int LOOKAHEAD  = 20,
   parameter int CW         = 8,
   parameter int RESET_BASE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [AW-1:0] flush_base,
   input  logic [AW-1:0] pc,
   input  logic          req_ready,
   input  logic          rsp_valid,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   output logic          wr_en
);
   localparam logic [AW-1:0] BURST_A = AW'(BURST);
   localparam logic [AW-1:0] LA_A    = AW'(LOOKAHEAD);
   localparam logic [CW-1:0] BURST_C = CW'(BURST);

   logic [AW-1:0] req_end;
   logic [AW-1:0] gap;
   logic [CW-1:0] pend, pend_nx, drop;
   logic          req_fire;

   always_comb begin
      gap       = req_end + BURST_A - pc;
      req_valid = (drop == '0) && (gap[AW-1] || (gap <= LA_A));
      req_fire  = req_valid && req_ready;
      pend_nx   = pend + (req_fire ? BURST_C : '0) - CW'(rsp_valid);
      wr_en     = rsp_valid && (drop == '0) && !flush;
   end

   assign req_addr = req_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_end <= AW'(RESET_BASE);
         pend    <= '0;
         drop    <= '0;
      end else begin
         pend <= pend_nx;
         if (flush) begin
            req_end <= flush_base;
            drop    <= pend_nx;
         end else begin
            if (req_fire) req_end <= req_end + BURST_A;
            if (rsp_valid && (drop != '0)) drop <= drop - CW'(1);
         end
      end
   end
endmodule

// File: rtl/pfs_bank_store.sv
module pfs_bank_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   parameter int NBANK = 2
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_slot,
   input  logic [DW-1:0]            wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_slot,
   output logic [DW-1:0]            rd_data
);
   localparam int SW   = $clog2(DEPTH);
   localparam int BB   = $clog2(NBANK);
   localparam int ROWS = DEPTH / NBANK;

   logic [DW-1:0] bank_q [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] row [ROWS];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot[BB-1:0] == BB'(b)))
            row[wr_slot[SW-1:BB]] <= wr_data;
      end
      assign bank_q[b] = row[rd_slot[SW-1:BB]];
   end

   assign rd_data = bank_q[rd_slot[BB-1:0]];
endmodule

// File: rtl/pfs_prefetch_stack.sv
module pfs_prefetch_stack
   import pfs_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int DEPTH     = 32,
   parameter int NBANK     = 2,
   parameter int BURST     = 4,
   parameter int FWD_WIN   = 9,
   parameter int BWD_WIN   = 11,
   parameter int LOOKAHEAD = 20,
   parameter int RESET_PC  = 0,
   parameter int CW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          req_valid,
   input  logic          req_ready,
   output logic [AW-1:0] req_addr,
   input  logic          rsp_valid,
   input  logic [DW-1:0] rsp_data,
   input  logic          br_valid,
   input  logic [1:0]    br_kind,
   input  logic [AW-1:0] br_operand,
   input  logic          stall,
   output logic          issue_valid,
   output logic [AW-1:0] issue_addr,
   output logic [DW-1:0] issue_parcel
);
   localparam int SW = $clog2(DEPTH);
   localparam int OW = SW + 1;
   localparam logic [AW-1:0] ALIGN    = ~AW'(BURST - 1);
   localparam logic [AW-1:0] RST_PC   = AW'(RESET_PC);
   localparam logic [AW-1:0] RST_BASE = RST_PC & ALIGN;
   localparam logic [OW-1:0] FULL     = OW'(DEPTH);

   if ((1 << SW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (((BURST & (BURST - 1)) != 0) || (DEPTH % BURST != 0)) begin : g_bad_burst
      $error("BURST must be a power of two dividing DEPTH");
   end
   if ((NBANK < 2) || ((NBANK & (NBANK - 1)) != 0) || (DEPTH % NBANK != 0)) begin : g_bad_bank
      $error("NBANK must be a power of two of at least 2 dividing DEPTH");
   end
   if ((LOOKAHEAD >= DEPTH) || (BWD_WIN >= DEPTH) || (LOOKAHEAD < BURST)) begin : g_bad_window
      $error("LOOKAHEAD and BWD_WIN must fit inside DEPTH");
   end

   logic [AW-1:0] pc, base, wend;
   logic [OW-1:0] occ;
   logic [AW-1:0] lo, rel, rd_off, wr_off;
   logic [AW-1:0] target, flush_base;
   logic          in_stack, fire, flush, wr_en;

   always_comb begin
      lo          = wend - AW'(occ);
      rel         = pc - lo;
      issue_valid = (rel < AW'(occ));
      rd_off      = pc - base;
      wr_off      = wend - base;
      fire        = issue_valid && !stall;
      flush       = fire && br_valid && !in_stack;
      flush_base  = target & ALIGN;
   end

   assign issue_addr = pc;

   pfs_branch_resolve #(
      .AW(AW), .DEPTH(DEPTH), .FWD_WIN(FWD_WIN), .BWD_WIN(BWD_WIN)
   ) i_resolve (
      .kind    (br_kind),
      .operand (br_operand),
      .pc      (pc),
      .base    (base),
      .req_end (req_addr),
      .target  (target),
      .in_stack(in_stack)
   );

   pfs_fetch_ctl #(
      .AW(AW), .BURST(BURST), .LOOKAHEAD(LOOKAHEAD), .CW(CW),
      .RESET_BASE(int'(RST_BASE))
   ) i_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .flush_base(flush_base),
      .pc        (pc),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .wr_en     (wr_en)
   );

   pfs_bank_store #(
      .DW(DW), .DEPTH(DEPTH), .NBANK(NBANK)
   ) i_store (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_slot(wr_off[SW-1:0]),
      .wr_data(rsp_data),
      .rd_slot(rd_off[SW-1:0]),
      .rd_data(issue_parcel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc   <= RST_PC;
         base <= RST_BASE;
         wend <= RST_BASE;
         occ  <= '0;
      end else if (flush) begin
         pc   <= target;
         base <= flush_base;
         wend <= flush_base;
         occ  <= '0;
      end else begin
         if (wr_en) begin
            wend <= wend + AW'(1);
            if (occ != FULL) occ <= occ + OW'(1);
         end
         if (fire) pc <= br_valid ? target : pc + AW'(1);
      end
   end
endmodule

// File: rtl/pfs_prefetch_stack_chk.sv
module pfs_prefetch_stack_chk #(
   parameter int AW      = 16,
   parameter int BURST   = 4,
   parameter int FWD_WIN = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          br_valid,
   input logic [1:0]    br_kind,
   input logic [AW-1:0] br_operand,
   input logic          stall,
   input logic          issue_valid,
   input logic [AW-1:0] issue_addr
);
   localparam logic [AW-1:0] LOW_MASK = AW'(BURST - 1);

   logic go;
   assign go = issue_valid && !stall;

   p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((req_addr & LOW_MASK) == '0));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !br_valid) |=> (issue_addr == AW'($past(issue_addr) + AW'(1))));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(issue_addr));

   p_abs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && br_valid && (br_kind == 2'd0 || br_kind == 2'd3))
      |=> (!issue_valid && (issue_addr == $past(br_operand))));

   p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && br_valid && br_kind == 2'd1 && br_operand <= AW'(FWD_WIN))
      |=> (issue_addr == AW'($past(issue_addr) + $past(br_operand))));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(issue_addr));
endmodule

bind pfs_prefetch_stack pfs_prefetch_stack_chk #(
   .AW(AW), .BURST(BURST), .FWD_WIN(FWD_WIN)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .br_valid   (br_valid),
   .br_kind    (br_kind),
   .br_operand (br_operand),
   .stall      (stall),
   .issue_valid(issue_valid),
   .issue_addr (issue_addr)
);

// File: tb/test_pfs_prefetch_stack.sv
module test_pfs_prefetch_stack;
   localparam int M  = 65535;
   localparam int DP = 32;
   localparam int BU = 4;
   localparam int LA = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready;
   logic [15:0] req_addr;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic        br_valid;
   logic [1:0]  br_kind;
   logic [15:0] br_operand;
   logic        stall;
   logic        issue_valid;
   logic [15:0] issue_addr, issue_parcel;

   always #10 clk = ~clk;

   pfs_prefetch_stack i_pfs_prefetch_stack (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .br_valid(br_valid), .br_kind(br_kind), .br_operand(br_operand),
      .stall(stall),
      .issue_valid(issue_valid), .issue_addr(issue_addr), .issue_parcel(issue_parcel)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   int m_pc, m_base, m_wend, m_occ, m_rend, m_pend, m_drop;
   int mq[$];
   string last_tag;

   function automatic int pdata(int a);
      return ((a * 40503) ^ (a >> 3) ^ 23130) & M;
   endfunction

   function automatic int sd(int a, int b);
      int d = (a - b) & M;
      if (d >= 32768) d -= 65536;
      return d;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   initial begin
      int idle;
      rst_n = 1'b0;
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
      br_valid = 1'b0; br_kind = '0; br_operand = '0; stall = 1'b0;
      m_pc = 0; m_base = 0; m_wend = 0; m_occ = 0; m_rend = 0; m_pend = 0; m_drop = 0;
      last_tag = "R4";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 issue_valid", int'(issue_valid), 0);
      chk("R1 issue_addr", int'(issue_addr), 0);
      chk("R1 req_valid", int'(req_valid), 1);
      chk("R1 req_addr", int'(req_addr), 0);
      idle = 0;
      for (int cyc = 0; cyc < 30000; cyc++) begin
         int e_valid, e_rv, fire, flush, ins, tgt, rfire, pend_nx, wr, push_a, r, rv;
         @(negedge clk);
         stall     = (($urandom % 4) == 0);
         req_ready = (($urandom % 3) != 0);
         rv        = (mq.size() > 0) && (($urandom % 4) != 0);
         rsp_valid = rv[0];
         rsp_data  = rv ? 16'(pdata(mq[0])) : 16'h0;
         br_valid  = (($urandom % 5) == 0);
         r = $urandom % 8;
         if (r == 0) begin br_kind = 2'd0; br_operand = 16'($urandom % 512); end
         else if (r == 1) begin br_kind = 2'd3; br_operand = 16'($urandom % 512); end
         else if (r < 5) begin br_kind = 2'd1; br_operand = 16'($urandom % 13); end
         else begin br_kind = 2'd2; br_operand = 16'(1 + $urandom % 15); end
         #1;
         e_valid = (((m_pc - (m_wend - m_occ)) & M) < m_occ) ? 1 : 0;
         e_rv    = (m_drop == 0 && sd(m_rend + BU, m_pc) <= LA) ? 1 : 0;
         chk("R4 issue_valid", int'(issue_valid), e_valid);
         chk({last_tag, " issue_addr"}, int'(issue_addr), m_pc);
         if (e_valid != 0) chk("R3/R9 issue_parcel", int'(issue_parcel), pdata(m_pc));
         chk("R2 req_valid", int'(req_valid), e_rv);
         if (e_rv != 0) chk("R2 req_addr", int'(req_addr), m_rend);
         // model step for the coming clock edge
         fire  = e_valid && !stall;
         ins   = 0; tgt = 0;
         if (br_kind == 2'd1) begin
            tgt = (m_pc + br_operand) & M; ins = (br_operand <= 9);
         end else if (br_kind == 2'd2) begin
            tgt = (m_pc - br_operand) & M;
            ins = (br_operand <= 11) && sd(tgt, m_base) >= 0 && sd(tgt, m_rend - DP) >= 0;
         end else begin
            tgt = br_operand;
         end
         flush   = fire && br_valid && !ins;
         rfire   = e_rv && req_ready;
         push_a  = m_rend;
         pend_nx = m_pend + (rfire ? BU : 0) - rv;
         wr      = rv && m_drop == 0 && !flush;
         if (flush) begin
            m_pc = tgt; m_base = tgt & ~(BU - 1); m_wend = m_base; m_occ = 0;
            m_rend = m_base; m_drop = pend_nx;
         end else begin
            if (wr) begin m_wend = (m_wend + 1) & M; if (m_occ < DP) m_occ++; end
            if (fire) m_pc = br_valid ? tgt : ((m_pc + 1) & M);
            if (rfire) m_rend = (m_rend + BU) & M;
            if (rv && m_drop > 0) m_drop--;
         end
         m_pend = pend_nx;
         if (rv) void'(mq.pop_front());
         if (rfire) for (int k = 0; k < BU; k++) mq.push_back((push_a + k) & M);
         if (br_valid && !fire) last_tag = "R10";
         else if (fire && br_valid && (br_kind == 2'd0 || br_kind == 2'd3)) last_tag = "R6";
         else if (fire && br_valid && br_kind == 2'd1) last_tag = "R7";
         else if (fire && br_valid && br_kind == 2'd2) last_tag = "R8";
         else if (stall) last_tag = "R5";
         else last_tag = "R4";
         if (fire) idle = 0; else idle++;
         if (idle > 3000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R4 actual=no_issue expected=progress");
            break;
         end
      end
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule